// File: doc/BRIEF.md
# Stop-and-Wait Retransmission Link Controller

This block implements both ends of a stop-and-wait retransmission link layer. The sending side takes one frame word from the layer above. It transmits that word tagged with a one-bit sequence number and keeps a copy. It then waits for a positive or negative acknowledgement from the link. A negative acknowledgement resends the held frame at once. If nothing usable arrives within a programmable number of cycles, the frame is also resent. Only a positive acknowledgement carrying the matching sequence bit releases the copy, toggles the sequence bit and lets the next frame in.

The receiving side takes frames from the link together with an integrity flag computed elsewhere. Frames flagged as damaged produce no response. So do frames that arrive while the local consumer is not ready, and the silence makes the far sender time out and resend. An intact frame whose sequence bit matches the expected bit is passed up and acknowledged. An intact frame with the other bit is a duplicate: it is acknowledged again but not passed up a second time.

The two sides share only clock and reset. In a system the sender's strobes reach a far receiver over a channel that lies outside this block.

Top module: `sw_arq_link`

## Requirements
- R1: While reset is held and right after it, tx_strobe, rx_ack_strobe and dlv_strobe are low, tx_seq is 0, and the receiver expects sequence bit 0.
- R2: When the sender is idle and up_req is high, up_accept is high in the same cycle. In the next cycle tx_strobe is high, with tx_frame equal to the accepted word and tx_seq equal to the current sequence bit.
- R3: From the cycle after acceptance until the frame is released, up_accept stays low whatever up_req does, so at most one frame is outstanding.
- R4: An ack_strobe with ack_seq equal to tx_seq, while awaiting a response, returns the sender to idle and inverts tx_seq. up_accept can then be high in the following cycle.
- R5: A nak_strobe while awaiting, with no matching acknowledgement in the same cycle, gives tx_strobe in the next cycle with the same tx_frame and tx_seq.
- R6: If no acknowledgement or NAK is seen for TIMEOUT_CYC awaiting cycles, the held frame is sent again, so consecutive unanswered tx_strobe pulses are TIMEOUT_CYC+1 cycles apart.
- R7: An ack_strobe whose ack_seq differs from tx_seq has no effect: no release, no sequence change and no retransmission.
- R8: A received frame with rx_good low, or one arriving while rx_ready is low, produces neither rx_ack_strobe nor dlv_strobe and leaves the expected bit unchanged.
- R9: An intact, accepted frame whose rx_seq equals the expected bit produces, one cycle later (RX_OUT_REG=1), dlv_strobe with dlv_frame equal to rx_frame and rx_ack_strobe with rx_ack_seq equal to rx_seq. The expected bit then toggles.
- R10: An intact, accepted frame whose rx_seq differs from the expected bit produces rx_ack_strobe with rx_ack_seq equal to rx_seq and no dlv_strobe.
- R11: When a matching ack_strobe and a nak_strobe arrive in the same awaiting cycle, the acknowledgement wins and no retransmission follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Upper layer offers a frame |
| up_frame | input | FRAME_W | Offered frame word |
| up_accept | output | 1 | Frame taken this cycle |
| tx_strobe | output | 1 | Frame is sent this cycle |
| tx_frame | output | FRAME_W | Frame word being sent |
| tx_seq | output | 1 | Sequence bit of the sent frame |
| ack_strobe | input | 1 | Positive acknowledgement received |
| ack_seq | input | 1 | Sequence bit carried by the acknowledgement |
| nak_strobe | input | 1 | Negative acknowledgement received |
| rx_strobe | input | 1 | Frame arrives from the link |
| rx_frame | input | FRAME_W | Arriving frame word |
| rx_seq | input | 1 | Sequence bit of the arriving frame |
| rx_good | input | 1 | Integrity check of the arriving frame passed |
| rx_ready | input | 1 | Local consumer can take a frame |
| rx_ack_strobe | output | 1 | Acknowledgement to send back |
| rx_ack_seq | output | 1 | Sequence bit for that acknowledgement |
| dlv_strobe | output | 1 | Frame delivered upward |
| dlv_frame | output | FRAME_W | Delivered frame word |

## Verification
The receiver is driven through a sequence of link frames: fresh frames with each sequence bit, a repeated bit, a damaged frame and a frame offered while not ready. This separates delivery, duplicate re-acknowledgement and silent discard, and shows the expected bit toggling only on fresh frames. The sender is driven through the patterns that release or resend a frame: a NAK, an acknowledgement with the wrong bit, a matching acknowledgement, an unanswered wait, and a simultaneous acknowledgement and NAK. Together these separate release from retransmission and measure the timeout spacing exactly. An offer made during the wait shows that a second frame is held back.

// File: rtl/sw_arq_pkg.sv
package sw_arq_pkg;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_SEND = 2'd1,
      TX_WAIT = 2'd2
   } tx_state_e;

   function automatic int unsigned cnt_width(input int unsigned cyc);
      return (cyc < 2) ? 1 : $clog2(cyc);
   endfunction

endpackage

// File: rtl/sw_arq_timer.sv
module sw_arq_timer #(
   parameter int unsigned CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic expired
);
   localparam int unsigned CW = sw_arq_pkg::cnt_width(CYC);
   localparam logic [CW-1:0] RELOAD = CW'(CYC - 1);

   logic [CW-1:0] cnt;

   // R6: reload on every send, count down while awaiting
   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= RELOAD;
      else if (run && cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = run && (cnt == '0);

endmodule

// File: rtl/sw_arq_tx.sv
module sw_arq_tx
   import sw_arq_pkg::*;
#(
   parameter int unsigned FRAME_W     = 8,
   parameter int unsigned TIMEOUT_CYC = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               up_req,
   input  logic [FRAME_W-1:0] up_frame,
   output logic               up_accept,
   output logic               tx_strobe,
   output logic [FRAME_W-1:0] tx_frame,
   output logic               tx_seq,
   input  logic               ack_strobe,
   input  logic               ack_seq,
   input  logic               nak_strobe,
   output logic               awaiting
);
   tx_state_e          state, state_nx;
   logic [FRAME_W-1:0] held;
   logic               seq;
   logic               ack_ok;
   logic               expired;

   assign awaiting  = (state == TX_WAIT);
   assign up_accept = (state == TX_IDLE) && up_req;
   assign tx_strobe = (state == TX_SEND);
   assign tx_frame  = held;
   assign tx_seq    = seq;
   // R4/R7: only a matching acknowledgement counts
   assign ack_ok    = awaiting && ack_strobe && (ack_seq == seq);

   sw_arq_timer #(.CYC(TIMEOUT_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tx_strobe),
      .run     (awaiting),
      .expired (expired)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         TX_IDLE: if (up_req) state_nx = TX_SEND;
         TX_SEND: state_nx = TX_WAIT;
         TX_WAIT: begin
            // R11: acknowledgement takes priority over NAK and timeout
            if (ack_ok)
               state_nx = TX_IDLE;
            else if (nak_strobe || expired)
               state_nx = TX_SEND;
         end
         default: state_nx = TX_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= TX_IDLE;
         held  <= '0;
         seq   <= 1'b0;
      end else begin
         state <= state_nx;
         if (up_accept) held <= up_frame;
         if (ack_ok)    seq  <= ~seq;
      end
   end

endmodule

// File: rtl/sw_arq_rx.sv
module sw_arq_rx #(
   parameter int unsigned FRAME_W    = 8,
   parameter bit          RX_OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_strobe,
   input  logic [FRAME_W-1:0] rx_frame,
   input  logic               rx_seq,
   input  logic               rx_good,
   input  logic               rx_ready,
   output logic               rx_ack_strobe,
   output logic               rx_ack_seq,
   output logic               dlv_strobe,
   output logic [FRAME_W-1:0] dlv_frame
);
   logic expect_seq;
   logic take;
   logic fresh;

   // R8: damaged or unready frames are dropped silently
   assign take  = rx_strobe && rx_good && rx_ready;
   // R9/R10: only the expected bit is delivered
   assign fresh = take && (rx_seq == expect_seq);

   always_ff @(posedge clk) begin
      if (!rst_n)
         expect_seq <= 1'b0;
      else if (fresh)
         expect_seq <= ~expect_seq;
   end

   generate
      if (RX_OUT_REG) begin : g_out_reg
         logic               ack_q, ack_seq_q, dlv_q;
         logic [FRAME_W-1:0] frame_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ack_q     <= 1'b0;
               ack_seq_q <= 1'b0;
               dlv_q     <= 1'b0;
               frame_q   <= '0;
            end else begin
               ack_q     <= take;
               dlv_q     <= fresh;
               if (take)  ack_seq_q <= rx_seq;
               if (fresh) frame_q   <= rx_frame;
            end
         end
         assign rx_ack_strobe = ack_q;
         assign rx_ack_seq    = ack_seq_q;
         assign dlv_strobe    = dlv_q;
         assign dlv_frame     = frame_q;
      end else begin : g_out_comb
         assign rx_ack_strobe = take;
         assign rx_ack_seq    = rx_seq;
         assign dlv_strobe    = fresh;
         assign dlv_frame     = rx_frame;
      end
   endgenerate

endmodule

// File: rtl/sw_arq_link.sv
module sw_arq_link #(
   parameter int unsigned FRAME_W     = 8,
   parameter int unsigned TIMEOUT_CYC = 16,
   parameter bit          RX_OUT_REG  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               up_req,
   input  logic [FRAME_W-1:0] up_frame,
   output logic               up_accept,
   output logic               tx_strobe,
   output logic [FRAME_W-1:0] tx_frame,
   output logic               tx_seq,
   input  logic               ack_strobe,
   input  logic               ack_seq,
   input  logic               nak_strobe,
   input  logic               rx_strobe,
   input  logic [FRAME_W-1:0] rx_frame,
   input  logic               rx_seq,
   input  logic               rx_good,
   input  logic               rx_ready,
   output logic               rx_ack_strobe,
   output logic               rx_ack_seq,
   output logic               dlv_strobe,
   output logic [FRAME_W-1:0] dlv_frame
);
   generate
      if (FRAME_W < 1) begin : g_bad_width
         $error("sw_arq_link: FRAME_W must be at least 1");
      end
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("sw_arq_link: TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   logic awaiting;

   sw_arq_tx #(
      .FRAME_W     (FRAME_W),
      .TIMEOUT_CYC (TIMEOUT_CYC)
   ) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .up_req     (up_req),
      .up_frame   (up_frame),
      .up_accept  (up_accept),
      .tx_strobe  (tx_strobe),
      .tx_frame   (tx_frame),
      .tx_seq     (tx_seq),
      .ack_strobe (ack_strobe),
      .ack_seq    (ack_seq),
      .nak_strobe (nak_strobe),
      .awaiting   (awaiting)
   );

   sw_arq_rx #(
      .FRAME_W    (FRAME_W),
      .RX_OUT_REG (RX_OUT_REG)
   ) u_rx (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_strobe     (rx_strobe),
      .rx_frame      (rx_frame),
      .rx_seq        (rx_seq),
      .rx_good       (rx_good),
      .rx_ready      (rx_ready),
      .rx_ack_strobe (rx_ack_strobe),
      .rx_ack_seq    (rx_ack_seq),
      .dlv_strobe    (dlv_strobe),
      .dlv_frame     (dlv_frame)
   );

endmodule

// File: rtl/sw_arq_link_chk.sv
module sw_arq_link_chk #(
   parameter int unsigned FRAME_W    = 8,
   parameter bit          RX_OUT_REG = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               up_req,
   input logic [FRAME_W-1:0] up_frame,
   input logic               up_accept,
   input logic               tx_strobe,
   input logic [FRAME_W-1:0] tx_frame,
   input logic               tx_seq,
   input logic               ack_strobe,
   input logic               ack_seq,
   input logic               nak_strobe,
   input logic               awaiting,
   input logic               rx_strobe,
   input logic               rx_good,
   input logic               rx_ready,
   input logic               rx_ack_strobe,
   input logic               dlv_strobe
);
   // R2
   accept_then_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_accept |=> tx_strobe && (tx_frame == $past(up_frame)));

   // R2
   accept_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_accept |-> up_req);

   // R3
   single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (awaiting || tx_strobe) |-> !up_accept);

   // R4
   ack_toggles_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (awaiting && ack_strobe && ack_seq == tx_seq) |=> (tx_seq != $past(tx_seq)) && !tx_strobe);

   // R5
   nak_resend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (awaiting && nak_strobe && !(ack_strobe && ack_seq == tx_seq))
         |=> tx_strobe && $stable(tx_frame) && $stable(tx_seq));

   // R7
   wrong_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (awaiting && ack_strobe && ack_seq != tx_seq) |=> $stable(tx_seq));

   // R9
   deliver_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_strobe |-> rx_ack_strobe);

   generate
      if (RX_OUT_REG) begin : g_reg_chk
         // R8
         drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_strobe && !(rx_good && rx_ready)) |=> !rx_ack_strobe && !dlv_strobe);
      end else begin : g_comb_chk
         // R8
         drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_strobe && !(rx_good && rx_ready)) |-> !rx_ack_strobe && !dlv_strobe);
      end
   endgenerate

endmodule

bind sw_arq_link sw_arq_link_chk #(
   .FRAME_W    (FRAME_W),
   .RX_OUT_REG (RX_OUT_REG)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .up_req        (up_req),
   .up_frame      (up_frame),
   .up_accept     (up_accept),
   .tx_strobe     (tx_strobe),
   .tx_frame      (tx_frame),
   .tx_seq        (tx_seq),
   .ack_strobe    (ack_strobe),
   .ack_seq       (ack_seq),
   .nak_strobe    (nak_strobe),
   .awaiting      (awaiting),
   .rx_strobe     (rx_strobe),
   .rx_good       (rx_good),
   .rx_ready      (rx_ready),
   .rx_ack_strobe (rx_ack_strobe),
   .dlv_strobe    (dlv_strobe)
);

// File: tb/sw_arq_link_tb_top.sv
module sw_arq_link_tb_top;
   localparam int unsigned FW  = 8;
   localparam int unsigned TMO = 6;
   localparam int NV = 7;
   // {good, ready, seq, frame[7:0], exp_dlv, exp_ack}
   localparam logic [12:0] RXV [NV] = '{
      {1'b1, 1'b1, 1'b0, 8'h11, 1'b1, 1'b1},
      {1'b1, 1'b1, 1'b0, 8'h22, 1'b0, 1'b1},
      {1'b0, 1'b1, 1'b1, 8'h33, 1'b0, 1'b0},
      {1'b1, 1'b0, 1'b1, 8'h44, 1'b0, 1'b0},
      {1'b1, 1'b1, 1'b1, 8'h55, 1'b1, 1'b1},
      {1'b1, 1'b1, 1'b0, 8'h66, 1'b1, 1'b1},
      {1'b1, 1'b1, 1'b0, 8'h77, 1'b0, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          up_req = 1'b0;
   logic [FW-1:0] up_frame = '0;
   logic          up_accept, tx_strobe, tx_seq;
   logic [FW-1:0] tx_frame;
   logic          ack_strobe = 1'b0, ack_seq = 1'b0, nak_strobe = 1'b0;
   logic          rx_strobe = 1'b0, rx_seq = 1'b0, rx_good = 1'b0, rx_ready = 1'b0;
   logic [FW-1:0] rx_frame = '0;
   logic          rx_ack_strobe, rx_ack_seq, dlv_strobe;
   logic [FW-1:0] dlv_frame;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   sw_arq_link #(.FRAME_W(FW), .TIMEOUT_CYC(TMO), .RX_OUT_REG(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_frame(up_frame),
      .up_accept(up_accept), .tx_strobe(tx_strobe), .tx_frame(tx_frame),
      .tx_seq(tx_seq), .ack_strobe(ack_strobe), .ack_seq(ack_seq),
      .nak_strobe(nak_strobe), .rx_strobe(rx_strobe), .rx_frame(rx_frame),
      .rx_seq(rx_seq), .rx_good(rx_good), .rx_ready(rx_ready),
      .rx_ack_strobe(rx_ack_strobe), .rx_ack_seq(rx_ack_seq),
      .dlv_strobe(dlv_strobe), .dlv_frame(dlv_frame)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   initial begin
      #4_000_000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int gap;
      repeat (3) step();
      // R1: reset state
      check("R1 tx_strobe", tx_strobe, 0);
      check("R1 tx_seq", tx_seq, 0);
      check("R1 rx_ack", rx_ack_strobe, 0);
      check("R1 dlv", dlv_strobe, 0);
      rst_n = 1'b1;
      step();
      check("R1 tx_strobe after reset", tx_strobe, 0);

      // R2: accept and send
      up_req = 1'b1; up_frame = 8'hA5;
      #1 check("R2 accept", up_accept, 1);
      step();
      up_req = 1'b0;
      check("R2 tx_strobe", tx_strobe, 1);
      check("R2 tx_frame", tx_frame, 8'hA5);
      check("R2 tx_seq", tx_seq, 0);
      step();
      // R3: new offer while awaiting is held back; R5: NAK
      up_req = 1'b1; up_frame = 8'h3C; nak_strobe = 1'b1;
      #1 check("R3 no accept while waiting", up_accept, 0);
      step();
      nak_strobe = 1'b0;
      check("R5 resend strobe", tx_strobe, 1);
      check("R5 resend frame", tx_frame, 8'hA5);
      check("R5 resend seq", tx_seq, 0);
      check("R3 no accept during resend", up_accept, 0);
      step();
      // R7: wrong-bit acknowledgement
      ack_strobe = 1'b1; ack_seq = 1'b1;
      step();
      ack_strobe = 1'b0;
      check("R7 no resend", tx_strobe, 0);
      check("R7 not released", up_accept, 0);
      check("R7 seq kept", tx_seq, 0);
      // R4: matching acknowledgement
      ack_strobe = 1'b1; ack_seq = 1'b0;
      step();
      ack_strobe = 1'b0;
      check("R4 released", up_accept, 1);
      check("R4 seq toggled", tx_seq, 1);
      step();
      up_req = 1'b0;
      check("R2 second send", tx_strobe, 1);
      check("R2 second frame", tx_frame, 8'h3C);
      check("R2 second seq", tx_seq, 1);
      // R6: timeout spacing
      gap = 0;
      for (int k = 1; k <= 4 * TMO; k++) begin
         step();
         if (tx_strobe && gap == 0) gap = k;
      end
      check("R6 timeout gap", gap, TMO + 1);
      // resynchronise to a send cycle
      while (!tx_strobe) step();
      step();
      // R11: ack and NAK together
      ack_strobe = 1'b1; ack_seq = 1'b1; nak_strobe = 1'b1;
      step();
      ack_strobe = 1'b0; nak_strobe = 1'b0;
      check("R11 no resend", tx_strobe, 0);
      check("R11 seq toggled", tx_seq, 0);
      up_req = 1'b1; up_frame = 8'h5A;
      #1 check("R11 idle accepts", up_accept, 1);
      step();
      up_req = 1'b0;

      // Receiver vector walk (R8, R9, R10)
      for (int i = 0; i < NV; i++) begin
         rx_strobe = 1'b1;
         rx_good   = RXV[i][12];
         rx_ready  = RXV[i][11];
         rx_seq    = RXV[i][10];
         rx_frame  = RXV[i][9:2];
         step();
         rx_strobe = 1'b0;
         if (!RXV[i][0]) begin
            check("R8 no ack", rx_ack_strobe, 0);
            check("R8 no deliver", dlv_strobe, 0);
         end else if (RXV[i][1]) begin
            check("R9 deliver", dlv_strobe, 1);
            check("R9 frame", dlv_frame, RXV[i][9:2]);
            check("R9 ack seq", rx_ack_seq, RXV[i][10]);
         end else begin
            check("R10 dup ack", rx_ack_strobe, 1);
            check("R10 dup not delivered", dlv_strobe, 0);
            check("R10 dup ack seq", rx_ack_seq, RXV[i][10]);
         end
         step();
         check("R9 strobes single cycle", dlv_strobe | rx_ack_strobe, 0);
      end

      // R1: reset clears receiver expectation (seq 0 is fresh again)
      rst_n = 1'b0;
      step();
      rst_n = 1'b1;
      rx_strobe = 1'b1; rx_good = 1'b1; rx_ready = 1'b1; rx_seq = 1'b0; rx_frame = 8'hE7;
      step();
      rx_strobe = 1'b0;
      check("R1 expects 0 after reset", dlv_strobe, 1);
      step();

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule